// File: doc/BRIEF.md
# USB OUT Endpoint Controller

This block holds the control, status and packet storage for one bulk or interrupt OUT endpoint of a USB device. On the protocol side, a packet engine signals a token start, delivers received data bytes one per strobe, and closes each packet with an end strobe that carries a good/bad flag and the received DATA0/DATA1 PID. One cycle later the block answers with a handshake choice of ACK, NAK or STALL.

On the processor side there is a single 32-bit control/status word, read combinationally and written with a one-cycle strobe. A byte read port drains the committed packet in arrival order, and a level interrupt reports a pending packet. Status bits have separate owners. The USB side sets packet-ready and sent-stall. The processor clears them. When both act on a bit in the same cycle, the USB-side set wins. The processor can also let a drain of the last byte clear packet-ready, discard a pending packet, force STALL, and reset the data toggle.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset the word reads 0. Bits 31:8, 5, 2 and 1 always read 0.
- R2: A good packet is handled as follows when no stall is forced, it is no longer than MAX_PKT, bit 0 is 0 and its PID matches the expected toggle. The block answers ACK, sets bit 0 (packet ready) and flips the expected toggle. hs_vld_o pulses in the cycle after pkt_end_i, with hs_o encoded 2'b01 ACK, 2'b10 NAK, 2'b11 STALL.
- R3: Writing 0 to bit 0 clears packet ready. Writing 1 to bit 0 never sets it.
- R4: With bit 7 (auto-clear) set, the fifo_rd_i read that removes the last byte of the committed packet clears bit 0.
- R5: irq_o is high while bit 0 is 1 and bit 6 (interrupt mask) is 0. Setting bit 6 masks it.
- R6: Writing 1 to bit 5 resets the expected toggle to DATA0.
- R7: A good packet longer than MAX_PKT bytes is answered with STALL. It sets bit 4 (sent-stall) and is not committed.
- R8: While bit 3 (force stall) is 1, every good packet is answered with STALL and sets bit 4. Clearing bit 3 restores normal handling.
- R9: Writing 0 to bit 4 clears it and writing 1 has no effect. A STALL in the same cycle as a clearing write leaves bit 4 at 1.
- R10: Writing 1 to bit 2 while bit 0 is 1 discards the packet and clears bit 0. While bit 0 is 0 the flush has no effect.
- R11: While bit 0 is 1, a good packet is answered with NAK and its bytes do not replace the stored packet.
- R12: A good packet with the wrong toggle is answered with ACK, but it is not committed and the expected toggle does not change.
- R13: A bad packet gets no handshake and changes no state.
- R14: fifo_rdata_o shows the committed bytes in arrival order, and each fifo_rd_i strobe advances to the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| fifo_rd_i | input | 1 | Pop one byte of the committed packet |
| fifo_rdata_o | output | 8 | Current packet byte |
| irq_o | output | 1 | Packet-ready interrupt |
| tok_out_i | input | 1 | OUT token start |
| rx_vld_i | input | 1 | Received data byte strobe |
| rx_byte_i | input | 8 | Received data byte |
| pkt_end_i | input | 1 | End of data packet |
| pkt_good_i | input | 1 | Packet passed checks (with pkt_end_i) |
| pkt_data1_i | input | 1 | Received PID is DATA1 (with pkt_end_i) |
| hs_vld_o | output | 1 | Handshake valid |
| hs_o | output | 2 | Handshake code |

## Verification
The bench goes after these corner cases:
- **Packet one byte past MAX_PKT.** An off-by-one length check would ACK and commit this packet instead of stalling it.
- **Zero-length packet.** It must still raise packet ready.
- **Repeated toggle.** A design that ignored the toggle would commit a duplicate.
- **Packet arriving while one is pending.** A missing NAK guard would overwrite the stored bytes.
- **Flush with nothing pending.** A design that applied it unconditionally would still behave, but the read-back would show whether the bit stuck.
- **Sent-stall cleared in the same cycle as a STALL.** Wrong priority would lose the stall flag.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
  localparam logic [1:0] HS_NONE  = 2'b00;
  localparam logic [1:0] HS_ACK   = 2'b01;
  localparam logic [1:0] HS_NAK   = 2'b10;
  localparam logic [1:0] HS_STALL = 2'b11;

  localparam int unsigned B_RDY   = 0;
  localparam int unsigned B_FLUSH = 2;
  localparam int unsigned B_HOLD  = 3;
  localparam int unsigned B_SENT  = 4;
  localparam int unsigned B_TCLR  = 5;
  localparam int unsigned B_MASK  = 6;
  localparam int unsigned B_AUTO  = 7;
endpackage

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx
  import usb_out_ep_pkg::*;
#(
  parameter int unsigned MAX_PKT = 64,
  localparam int unsigned CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_i,
  input  logic          byte_vld_i,
  input  logic          pkt_end_i,
  input  logic          pkt_good_i,
  input  logic          pid_data1_i,
  input  logic          stall_hold_i,
  input  logic          pkt_rdy_i,
  input  logic          exp_tog_i,
  output logic          wr_en_o,
  output logic [CW-1:0] cnt_o,
  output logic          commit_o,
  output logic          stall_evt_o,
  output logic          hs_vld_o,
  output logic [1:0]    hs_o
);
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic [1:0]    hs_d, hs_q;
  logic          at_max;

  assign at_max  = (cnt_q == CW'(MAX_PKT));
  assign wr_en_o = byte_vld_i && !pkt_rdy_i && !at_max;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (tok_i || pkt_end_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (byte_vld_i) begin
      if (at_max) ovf_q <= 1'b1;
      else        cnt_q <= cnt_q + CW'(1);
    end
  end

  // priority: bad > stall (forced or oversize) > busy > toggle
  always_comb begin
    hs_d        = HS_NONE;
    commit_o    = 1'b0;
    stall_evt_o = 1'b0;
    if (pkt_end_i && pkt_good_i) begin
      if (stall_hold_i || ovf_q) begin
        hs_d        = HS_STALL;
        stall_evt_o = 1'b1;
      end else if (pkt_rdy_i) begin
        hs_d = HS_NAK;
      end else begin
        hs_d     = HS_ACK;
        commit_o = (pid_data1_i == exp_tog_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_q <= HS_NONE;
    else         hs_q <= hs_d;
  end

  assign hs_vld_o = (hs_q != HS_NONE);
  assign hs_o     = hs_q;
endmodule

// File: rtl/usb_out_ep_buf.sv
module usb_out_ep_buf #(
  parameter int unsigned MAX_PKT = 64,
  localparam int unsigned AW = $clog2(MAX_PKT),
  localparam int unsigned CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_idx_i,
  input  logic [7:0]    wdata_i,
  input  logic          commit_i,
  input  logic          flush_i,
  input  logic          pkt_rdy_i,
  input  logic          rd_i,
  output logic [7:0]    rdata_o,
  output logic          last_rd_o
);
  logic [7:0]    mem [MAX_PKT];
  logic [CW-1:0] len_q, rd_q;
  logic          rd_ok;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_idx_i[AW-1:0]] <= wdata_i;
  end

  assign rd_ok     = rd_i && pkt_rdy_i && (rd_q < len_q);
  assign last_rd_o = rd_ok && (rd_q == len_q - CW'(1));
  assign rdata_o   = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      rd_q  <= '0;
    end else if (commit_i) begin
      len_q <= wr_idx_i;
      rd_q  <= '0;
    end else if (flush_i) begin
      len_q <= '0;
      rd_q  <= '0;
    end else if (rd_ok) begin
      rd_q <= rd_q + CW'(1);
    end
  end
endmodule

// File: rtl/usb_out_ep_csr.sv
module usb_out_ep_csr
  import usb_out_ep_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        commit_i,
  input  logic        stall_evt_i,
  input  logic        last_rd_i,
  output logic [31:0] rdata_o,
  output logic        pkt_rdy_o,
  output logic        exp_tog_o,
  output logic        stall_hold_o,
  output logic        flush_o,
  output logic        irq_o
);
  logic auto_q, mask_q, hold_q, sent_q, rdy_q, tog_q;

  assign flush_o = wr_i && wdata_i[B_FLUSH] && rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q <= 1'b0;
      mask_q <= 1'b0;
      hold_q <= 1'b0;
      sent_q <= 1'b0;
      rdy_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        auto_q <= wdata_i[B_AUTO];
        mask_q <= wdata_i[B_MASK];
        hold_q <= wdata_i[B_HOLD];
      end
      // USB-side events take priority over processor clears
      if (stall_evt_i)                    sent_q <= 1'b1;
      else if (wr_i && !wdata_i[B_SENT])  sent_q <= 1'b0;

      if (commit_i) rdy_q <= 1'b1;
      else if (flush_o || (wr_i && !wdata_i[B_RDY]) || (auto_q && last_rd_i))
        rdy_q <= 1'b0;

      if (commit_i)                      tog_q <= ~tog_q;
      else if (wr_i && wdata_i[B_TCLR])  tog_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o         = '0;
    rdata_o[B_AUTO] = auto_q;
    rdata_o[B_MASK] = mask_q;
    rdata_o[B_SENT] = sent_q;
    rdata_o[B_HOLD] = hold_q;
    rdata_o[B_RDY]  = rdy_q;
  end

  assign pkt_rdy_o    = rdy_q;
  assign exp_tog_o    = tog_q;
  assign stall_hold_o = hold_q;
  assign irq_o        = rdy_q && !mask_q;
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl #(
  parameter int unsigned MAX_PKT = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        fifo_rd_i,
  output logic [7:0]  fifo_rdata_o,
  output logic        irq_o,
  input  logic        tok_out_i,
  input  logic        rx_vld_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        pkt_end_i,
  input  logic        pkt_good_i,
  input  logic        pkt_data1_i,
  output logic        hs_vld_o,
  output logic [1:0]  hs_o
);
  localparam int unsigned CW = $clog2(MAX_PKT + 1);

  logic          wr_en, commit, stall_evt, last_rd;
  logic          pkt_rdy, exp_tog, stall_hold, flush;
  logic [CW-1:0] cnt;

  usb_out_ep_rx #(.MAX_PKT(MAX_PKT)) u_rx (
    .clk_i, .rst_ni,
    .tok_i        (tok_out_i),
    .byte_vld_i   (rx_vld_i),
    .pkt_end_i,
    .pkt_good_i,
    .pid_data1_i  (pkt_data1_i),
    .stall_hold_i (stall_hold),
    .pkt_rdy_i    (pkt_rdy),
    .exp_tog_i    (exp_tog),
    .wr_en_o      (wr_en),
    .cnt_o        (cnt),
    .commit_o     (commit),
    .stall_evt_o  (stall_evt),
    .hs_vld_o,
    .hs_o
  );

  usb_out_ep_buf #(.MAX_PKT(MAX_PKT)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_idx_i  (cnt),
    .wdata_i   (rx_byte_i),
    .commit_i  (commit),
    .flush_i   (flush),
    .pkt_rdy_i (pkt_rdy),
    .rd_i      (fifo_rd_i),
    .rdata_o   (fifo_rdata_o),
    .last_rd_o (last_rd)
  );

  usb_out_ep_csr u_csr (
    .clk_i, .rst_ni,
    .wr_i         (reg_wr_i),
    .wdata_i      (reg_wdata_i),
    .commit_i     (commit),
    .stall_evt_i  (stall_evt),
    .last_rd_i    (last_rd),
    .rdata_o      (reg_rdata_o),
    .pkt_rdy_o    (pkt_rdy),
    .exp_tog_o    (exp_tog),
    .stall_hold_o (stall_hold),
    .flush_o      (flush),
    .irq_o
  );
endmodule

// File: rtl/usb_out_ep_chk.sv
module usb_out_ep_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pkt_end_i,
  input logic        pkt_good_i,
  input logic        reg_wr_i,
  input logic        flush_bit_i,
  input logic [31:0] reg_rdata_o,
  input logic        irq_o,
  input logic        hs_vld_o,
  input logic [1:0]  hs_o
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & 32'hFFFF_FF26) == 32'h0);

  // R13
  bad_pkt_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_i && !pkt_good_i |=> !hs_vld_o);

  // R8
  hold_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_i && pkt_good_i && reg_rdata_o[3] |=> hs_vld_o && hs_o == 2'b11);

  // R7
  stall_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_vld_o && hs_o == 2'b11 |-> reg_rdata_o[4]);

  // R11
  nak_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_vld_o && hs_o == 2'b10 |-> $past(reg_rdata_o[0]));

  // R10
  flush_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && flush_bit_i && !reg_rdata_o[0] && !pkt_end_i |=> !reg_rdata_o[0]);

  // R5
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[0]) && !reg_rdata_o[6] |-> irq_o);
endmodule

bind usb_out_ep_ctrl usb_out_ep_chk u_chk (
  .clk_i, .rst_ni, .pkt_end_i, .pkt_good_i, .reg_wr_i,
  .flush_bit_i (reg_wdata_i[2]),
  .reg_rdata_o, .irq_o, .hs_vld_o, .hs_o
);

// File: tb/tb_usb_out_ep_ctrl.sv
module tb_usb_out_ep_ctrl;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_wr = 1'b0, fifo_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  fifo_rdata, rx_byte = '0;
  logic        irq, tok = 1'b0, rx_vld = 1'b0, pkt_end = 1'b0, pkt_good = 1'b0, pkt_d1 = 1'b0;
  logic        hs_vld;
  logic [1:0]  hs;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  usb_out_ep_ctrl #(.MAX_PKT(64)) dut (
    .clk_i(clk), .rst_ni, .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .fifo_rd_i(fifo_rd), .fifo_rdata_o(fifo_rdata), .irq_o(irq), .tok_out_i(tok),
    .rx_vld_i(rx_vld), .rx_byte_i(rx_byte), .pkt_end_i(pkt_end), .pkt_good_i(pkt_good),
    .pkt_data1_i(pkt_d1), .hs_vld_o(hs_vld), .hs_o(hs)
  );

  // {pid1, good, len[7:0], hs[1:0], rdy}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 1'b1, 8'd4,  2'b01, 1'b1},
    {1'b0, 1'b1, 8'd3,  2'b01, 1'b0},
    {1'b1, 1'b1, 8'd64, 2'b01, 1'b1},
    {1'b0, 1'b1, 8'd65, 2'b11, 1'b0},
    {1'b0, 1'b0, 8'd2,  2'b00, 1'b0},
    {1'b0, 1'b1, 8'd0,  2'b01, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // returns {hs_vld, hs}; optional register write in the end cycle
  task automatic send_pkt(input logic d1, input logic good, input int len, input logic [7:0] base,
                          input logic end_wr, input logic [31:0] end_wd, output logic [2:0] res);
    tok = 1'b1;
    @(negedge clk);
    tok = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_vld = 1'b1; rx_byte = base + 8'(i);
      @(negedge clk);
    end
    rx_vld = 1'b0;
    pkt_end = 1'b1; pkt_good = good; pkt_d1 = d1;
    reg_wr = end_wr; reg_wdata = end_wd;
    @(negedge clk);
    pkt_end = 1'b0; pkt_good = 1'b0; pkt_d1 = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    res = {hs_vld, hs};
  endtask

  task automatic read_byte(input string req, input logic [7:0] exp);
    chk(req, {24'h0, fifo_rdata}, {24'h0, exp});
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    // all ones: flush ignored, rdy/sent not set by 1, clear bits read 0
    reg_write(32'hFFFF_FFFF);
    chk("R1/R3/R9/R10 write all ones", reg_rdata, 32'h0000_00C8);
    reg_write(32'h0);

    // table walk: R2 R7 R12 R13 R14
    for (int v = 0; v < 6; v++) begin
      logic [7:0] len, base;
      len  = VEC[v][10:3];
      base = 8'(8'h10 * v);
      send_pkt(VEC[v][12], VEC[v][11], int'(len), base, 1'b0, 32'h0, r);
      chk("R2/R7/R12/R13 handshake", {29'h0, r}, {29'h0, (VEC[v][2:1] != 2'b00), VEC[v][2:1]});
      chk("R2/R12/R13 packet ready", {31'h0, reg_rdata[0]}, {31'h0, VEC[v][0]});
      chk("R7 sent-stall flag", {31'h0, reg_rdata[4]}, {31'h0, VEC[v][2:1] == 2'b11});
      if (VEC[v][0])
        for (int i = 0; i < int'(len); i++) read_byte("R14 byte order", base + 8'(i));
      reg_write(32'h0);
      chk("R3/R9 cleared by write 0", reg_rdata, 32'h0);
    end

    // R6: expected toggle is 1 now; clear it and send DATA0
    reg_write(32'h20);
    send_pkt(1'b0, 1'b1, 3, 8'hA0, 1'b0, 32'h0, r);
    chk("R6 DATA0 accepted after clear", {31'h0, reg_rdata[0]}, 32'h1);
    chk("R5 irq unmasked", {31'h0, irq}, 32'h1);
    reg_write(32'h41);
    chk("R5 irq masked", {31'h0, irq}, 32'h0);
    chk("R5 mask readback", reg_rdata, 32'h41);
    reg_write(32'h45);
    chk("R10 flush clears ready", reg_rdata, 32'h40);
    reg_write(32'h0);

    // R4: auto clear on last byte; toggle is 1
    reg_write(32'h80);
    send_pkt(1'b1, 1'b1, 3, 8'h30, 1'b0, 32'h0, r);
    read_byte("R4 byte0", 8'h30);
    read_byte("R4 byte1", 8'h31);
    chk("R4 still ready before last", {31'h0, reg_rdata[0]}, 32'h1);
    read_byte("R4 byte2", 8'h32);
    chk("R4 cleared on last read", {31'h0, reg_rdata[0]}, 32'h0);
    reg_write(32'h0);

    // R11: toggle is 0
    send_pkt(1'b0, 1'b1, 2, 8'h50, 1'b0, 32'h0, r);
    send_pkt(1'b1, 1'b1, 2, 8'h70, 1'b0, 32'h0, r);
    chk("R11 NAK while pending", {29'h0, r}, 32'h6);
    chk("R11 ready kept", {31'h0, reg_rdata[0]}, 32'h1);
    read_byte("R11 stored byte0", 8'h50);
    read_byte("R11 stored byte1", 8'h51);
    reg_write(32'h0);

    // R8/R9: toggle is 1
    reg_write(32'h08);
    send_pkt(1'b1, 1'b1, 1, 8'h90, 1'b0, 32'h0, r);
    chk("R8 forced STALL", {29'h0, r}, 32'h7);
    chk("R8 sent-stall set", reg_rdata, 32'h18);
    reg_write(32'h08);
    chk("R9 sent-stall cleared", reg_rdata, 32'h08);
    send_pkt(1'b1, 1'b1, 1, 8'h90, 1'b1, 32'h08, r);
    chk("R9 USB set wins", reg_rdata, 32'h18);
    reg_write(32'h0);
    send_pkt(1'b1, 1'b1, 1, 8'h91, 1'b0, 32'h0, r);
    chk("R8 normal after release", {29'h0, r}, 32'h5);
    chk("R8 committed after release", reg_rdata, 32'h01);
    read_byte("R14 single byte", 8'h91);
    finish_run();
  end
endmodule